// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address presented to a memory array on every clock of a short burst. A load cycle captures an externally supplied start address and opens a burst. Each following advance cycle moves the two least significant address bits to the next beat of a four-beat sequence. The upper address bits keep the value that was loaded.

Two beat orders are available, and a mode input chooses between them. In linear order the low bits count upward and wrap modulo four. In interleaved order they are the start value XOR-ed with the beat number. The mode is meant to be strapped and left fixed. A load cycle with the chip not selected ends the current burst. Holding the clock enable inactive stalls the whole block.

Top module: `burst_addr_gen`

## Requirements
- R1: During and directly after synchronous active-low reset, `cur_addr` is 0 and `burst_active` is 0.
- R2: A cycle with `ce_n`=0, `ld_n`=0 and `chip_sel`=1 loads `ext_addr`. From the next cycle `cur_addr` equals that address and `burst_active` is 1.
- R3: On an advance cycle (`ce_n`=0, `ld_n`=1), `ext_addr` has no effect on `cur_addr`.
- R4: With `ord_interleave`=0, after k advances of an active burst the low two bits of `cur_addr` equal (start + k) mod 4.
- R5: With `ord_interleave`=1, after k advances of an active burst the low two bits of `cur_addr` equal start XOR (k mod 4).
- R6: After four advances the address returns to the loaded start address, and the burst stays active.
- R7: Advance cycles never change `cur_addr` bits above bit 1.
- R8: A cycle with `ce_n`=0, `ld_n`=0 and `chip_sel`=0 clears `burst_active` from the next cycle and leaves `cur_addr` unchanged.
- R9: Advance cycles while `burst_active` is 0 leave `cur_addr` unchanged.
- R10: While `ce_n`=1, all other inputs are ignored. `cur_addr` and `burst_active` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ce_n | input | 1 | Clock enable, active low; high stalls the block |
| ld_n | input | 1 | Low = load/deselect cycle, high = advance cycle |
| chip_sel | input | 1 | High when the chip is selected on this cycle |
| ord_interleave | input | 1 | Static beat order: 1 interleaved, 0 linear |
| ext_addr | input | ADDR_W | Start address captured on a load cycle |
| cur_addr | output | ADDR_W | Current array address |
| burst_active | output | 1 | High while a burst is open |

## Verification
Every result is due exactly one clock after the edge that samples the command: load, advance, deselect and stall all take effect at that edge. `cur_addr` is then decoded combinationally from registers. The bench drives inputs on the falling edge. A bench model is updated on the following rising edge, and the outputs are compared on the next falling edge, so each comparison falls in the cycle its command is due. Random command mixes in both beat orders are combined with directed runs for wrap-around, address-upper hold, idle advance and stall.

// File: rtl/burst_pkg.sv
// Package: shared command encoding for the burst address sequencer.
// Assumes: consumers decode the four commands exhaustively.
package burst_pkg;
    typedef enum logic [1:0] {
        CMD_HOLD = 2'd0,   // clock enable inactive: nothing moves
        CMD_LOAD = 2'd1,   // capture start address, open burst
        CMD_END  = 2'd2,   // deselect load: close burst
        CMD_ADV  = 2'd3    // step to next beat
    } burst_cmd_e;
endpackage

// File: rtl/burst_cmd_decode.sv
// Module: turns the sampled control pins into one burst command.
// Assumes: all inputs are synchronous to clk; clock enable has top priority.
module burst_cmd_decode
    import burst_pkg::*;
(
    input  logic       ce_n,
    input  logic       ld_n,
    input  logic       chip_sel,
    output burst_cmd_e cmd
);
    // Priority decode: stall, then load/deselect, then advance.
    always_comb begin
        if (ce_n)
            cmd = CMD_HOLD;
        else if (!ld_n)
            cmd = chip_sel ? CMD_LOAD : CMD_END;
        else
            cmd = CMD_ADV;
    end
endmodule

// File: rtl/burst_step_ctrl.sv
// Module: keeps the burst-open flag and the beat counter.
// Assumes: the counter width sets the burst length (2**STEP_W beats) and wraps freely.
module burst_step_ctrl
    import burst_pkg::*;
#(
    parameter int STEP_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  burst_cmd_e        cmd,
    output logic              active,
    output logic [STEP_W-1:0] step
);
    localparam logic [STEP_W-1:0] STEP_ONE = STEP_W'(1);
    localparam logic [STEP_W-1:0] STEP_TOP = {STEP_W{1'b1}};

    // Flag and counter update per command; an idle advance changes nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            step   <= '0;
        end else begin
            unique case (cmd)
                CMD_LOAD: begin
                    active <= 1'b1;
                    step   <= '0;
                end
                CMD_END:  active <= 1'b0;
                CMD_ADV:  if (active) step <= step + STEP_ONE;
                default:  ;
            endcase
        end
    end

    // R6: the last beat of an open burst wraps the counter back to zero
    a_r6_step_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ADV && active && step == STEP_TOP) |=> (step == '0 && active));

    // R9: an advance with no open burst leaves the counter alone
    a_r9_idle_step: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_ADV && !active) |=> $stable(step) && !active);
endmodule

// File: rtl/burst_order_map.sv
// Module: maps start bits and beat count to the beat's low address bits.
// Assumes: order_il is static while a burst is open; purely combinational.
module burst_order_map #(
    parameter int STEP_W = 2
) (
    input  logic              order_il,
    input  logic [STEP_W-1:0] start_low,
    input  logic [STEP_W-1:0] step,
    output logic [STEP_W-1:0] beat_low
);
    // Linear order adds modulo the burst length; interleaved order flips bits.
    always_comb begin
        if (order_il)
            beat_low = start_low ^ step;
        else
            beat_low = start_low + step;
    end
endmodule

// File: rtl/burst_addr_gen.sv
// Module: top of the burst address sequencer. Holds the loaded start address
// and builds the current array address from it and the beat counter.
// Assumes: ord_interleave is strapped; ADDR_W > BURST_BITS.
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int BURST_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              ld_n,
    input  logic              chip_sel,
    input  logic              ord_interleave,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              burst_active
);
    localparam int HI_W = ADDR_W - BURST_BITS;
    localparam logic [BURST_BITS-1:0] LOW_ONE = BURST_BITS'(1);

    burst_cmd_e            cmd;
    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] step;
    logic [BURST_BITS-1:0] beat_low;

    burst_cmd_decode u_dec (
        .ce_n     (ce_n),
        .ld_n     (ld_n),
        .chip_sel (chip_sel),
        .cmd      (cmd)
    );

    burst_step_ctrl #(.STEP_W(BURST_BITS)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .cmd    (cmd),
        .active (burst_active),
        .step   (step)
    );

    // Start address register: captured only on a selected load.
    always_ff @(posedge clk) begin
        if (!rst_n)
            base_q <= '0;
        else if (cmd == CMD_LOAD)
            base_q <= ext_addr;
    end

    burst_order_map #(.STEP_W(BURST_BITS)) u_map (
        .order_il  (ord_interleave),
        .start_low (base_q[BURST_BITS-1:0]),
        .step      (step),
        .beat_low  (beat_low)
    );

    // Output address: loaded upper bits above the sequenced low bits.
    always_comb cur_addr = {base_q[ADDR_W-1:BURST_BITS], beat_low};

    // R2: a selected load shows the external address next cycle
    a_r2_load_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !ld_n && chip_sel) |=> (cur_addr == $past(ext_addr) && burst_active));

    // R8: a deselect load closes the burst and keeps the address
    a_r8_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && !ld_n && !chip_sel) |=> (!burst_active && $stable(cur_addr)));

    // R10: a stall freezes both outputs
    a_r10_stall: assert property (@(posedge clk) disable iff (!rst_n)
        ce_n |=> ($stable(cur_addr) && $stable(burst_active)));

    // R7: advances never touch the upper address bits
    a_r7_upper_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ld_n) |=> (cur_addr[ADDR_W-1 -: HI_W] == $past(cur_addr[ADDR_W-1 -: HI_W])));

    // R4: linear advance of an open burst moves the low bits up by one
    a_r4_linear_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ld_n && burst_active && !ord_interleave && $stable(ord_interleave))
        |=> (cur_addr[BURST_BITS-1:0] == $past(cur_addr[BURST_BITS-1:0]) + LOW_ONE));
endmodule

// File: tb/test_burst_addr_gen.sv
module test_burst_addr_gen;
    localparam int AW = 17;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1;
    logic          ld_n = 1'b1;
    logic          chip_sel = 1'b0;
    logic          ord_il = 1'b0;
    logic [AW-1:0] ext_addr = '0;
    logic [AW-1:0] cur_addr;
    logic          burst_active;

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;

    // Bench model state
    logic [AW-1:0] m_base = '0;
    logic [1:0]    m_step = '0;
    logic          m_act = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    burst_addr_gen #(.ADDR_W(AW), .BURST_BITS(2)) i_burst_addr_gen (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ld_n(ld_n), .chip_sel(chip_sel),
        .ord_interleave(ord_il), .ext_addr(ext_addr),
        .cur_addr(cur_addr), .burst_active(burst_active)
    );

    function automatic logic [AW-1:0] exp_addr(logic [AW-1:0] b, logic [1:0] s, logic il);
        logic [1:0] lo;
        lo = il ? (b[1:0] ^ s) : (b[1:0] + s);
        return {b[AW-1:2], lo};
    endfunction

    task automatic check(string tag, logic [AW-1:0] act_a, logic [AW-1:0] exp_a,
                         logic act_b, logic exp_b);
        n_cmp++;
        if (act_a !== exp_a || act_b !== exp_b) begin
            n_bad++;
            $display("FAIL %s: addr=%h active=%b expected addr=%h active=%b",
                     tag, act_a, act_b, exp_a, exp_b);
        end
    endtask

    // One cycle: drive at falling edge, update model at rising edge, compare at falling edge.
    task automatic run(logic c, logic l, logic s, logic [AW-1:0] a, string tag);
        ce_n = c; ld_n = l; chip_sel = s; ext_addr = a;
        @(posedge clk);
        cyc++;
        if (!rst_n) begin
            m_base = '0; m_step = '0; m_act = 1'b0;
        end else if (!c) begin
            if (!l) begin
                if (s) begin m_base = a; m_step = '0; m_act = 1'b1; end
                else m_act = 1'b0;
            end else if (m_act) m_step = m_step + 2'd1;
        end
        @(negedge clk);
        check(tag, cur_addr, exp_addr(m_base, m_step, ord_il), burst_active, m_act);
    endtask

    task automatic do_reset(logic il);
        rst_n = 1'b0;
        ord_il = il;
        run(1'b0, 1'b0, 1'b1, 17'h1abcd, "R1");
        run(1'b1, 1'b1, 1'b0, '0, "R1");
        rst_n = 1'b1;
    endtask

    // Watchdog
    initial begin
        #400000;
        n_cmp++; n_bad++;
        $display("FAIL watchdog: addr=%h expected run to finish", cur_addr);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] start;
        logic [AW-1:0] hi_before;
        void'($urandom(32'd4711));
        @(negedge clk);
        do_reset(1'b0);

        // R2/R4/R6: linear burst from low bits 2 -> 2,3,0,1 then wraps to 2
        start = 17'h0f3a2;
        run(1'b0, 1'b0, 1'b1, start, "R2");
        for (int k = 1; k <= 3; k++) run(1'b0, 1'b1, 1'b0, 17'h00000, "R4");
        run(1'b0, 1'b1, 1'b1, 17'h1ffff, "R6");
        check("R6", cur_addr, start, burst_active, 1'b1);

        // R3/R7: advance with a different external address; upper bits hold
        hi_before = cur_addr;
        run(1'b0, 1'b1, 1'b1, 17'h15555, "R3");
        check("R7", {cur_addr[AW-1:2], 2'b00}, {hi_before[AW-1:2], 2'b00}, 1'b1, 1'b1);

        // R10: stall with a load pattern on the other pins
        hi_before = cur_addr;
        run(1'b1, 1'b0, 1'b1, 17'h00001, "R10");
        check("R10", cur_addr, hi_before, burst_active, 1'b1);

        // R8 then R9: deselect holds address, idle advances do nothing
        hi_before = cur_addr;
        run(1'b0, 1'b0, 1'b0, 17'h12345, "R8");
        check("R8", cur_addr, hi_before, burst_active, 1'b0);
        run(1'b0, 1'b1, 1'b1, 17'h0aaaa, "R9");
        run(1'b0, 1'b1, 1'b0, 17'h0bbbb, "R9");
        check("R9", cur_addr, hi_before, burst_active, 1'b0);

        // Random linear traffic
        for (int i = 0; i < 1500; i++) begin
            int r;
            logic c, l, s;
            r = $urandom_range(0, 9);
            c = (r == 0); l = (r > 2); s = (r != 1);
            run(c, l, s, AW'($urandom),
                c ? "R10" : (!l ? (s ? "R2" : "R8") : (m_act ? "R4" : "R9")));
        end

        // R5/R6: interleaved burst from low bits 1 -> 1,0,3,2 then back to 1
        do_reset(1'b1);
        start = 17'h0a5f1;
        run(1'b0, 1'b0, 1'b1, start, "R2");
        run(1'b0, 1'b1, 1'b0, '0, "R5");
        check("R5", cur_addr, {start[AW-1:2], 2'b00}, burst_active, 1'b1);
        run(1'b0, 1'b1, 1'b0, '0, "R5");
        check("R5", cur_addr, {start[AW-1:2], 2'b11}, burst_active, 1'b1);
        run(1'b0, 1'b1, 1'b0, '0, "R5");
        run(1'b0, 1'b1, 1'b0, '0, "R6");
        check("R6", cur_addr, start, burst_active, 1'b1);

        // Random interleaved traffic
        for (int i = 0; i < 1500; i++) begin
            int r;
            logic c, l, s;
            r = $urandom_range(0, 9);
            c = (r == 0); l = (r > 2); s = (r != 1);
            run(c, l, s, AW'($urandom),
                c ? "R10" : (!l ? (s ? "R2" : "R8") : (m_act ? "R5" : "R9")));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule